// File: doc/BRIEF.md
# DRAM Bank Row-State Command Sequencer

This block sits between a memory controller's request scheduler and its DRAM command arbiter. For every bank of every rank it remembers which row is open, if any. When a request (read or write, with rank, bank, row and column) is accepted, it is expanded into a short ordered burst of DRAM commands. The burst is placed in that bank's private command queue. A bank with no open row gets an activate followed by the column command. A bank holding another row gets a precharge, an activate and the column command. A bank already holding the requested row gets the column command alone.

A request is accepted only while the target bank's queue is empty, so a bank never holds commands from two requests at once. One cycle after acceptance the block reports whether the request hit the open row. The arbiter downstream sees the head command of every bank queue and fires a per-bank issue strobe when it sends that command to the device. Issued activates and precharges update the bank's open-row record. Timing legality of the issue strobes belongs to the arbiter.

Top module: `dram_bank_cmd_seq`

## Requirements
- R1: After reset every bank queue is empty (`head_valid` all 0), no bank is open (`bank_open` all 0), `acc_valid` is 0 and `req_ready` is 1.
- R2: A request to a bank with no open row loads two commands: ACTIVATE, then the column command. `acc_hit` is 0.
- R3: A request to a bank holding a different row loads three commands: PRECHARGE, ACTIVATE, then the column command. `acc_hit` is 0.
- R4: A request to a bank holding the requested row loads only the column command. `acc_hit` is 1.
- R5: The column command is WRITE for `req_write`=1 and READ for `req_write`=0. The command encoding is PRECHARGE=0, ACTIVATE=1, READ=2, WRITE=3. Every queued command carries the request's row and column.
- R6: `req_ready` is 1 exactly when the addressed bank's queue is empty. A `req_valid` while `req_ready` is 0 is ignored: it leaves the queue unchanged and produces no `acc_valid`.
- R7: `issue[i]` removes the head of queue i, and commands leave strictly in load order. An issue strobe to an empty queue has no effect.
- R8: Issuing an ACTIVATE sets the bank open with its row, which the next request's hit decision uses. Issuing a PRECHARGE clears `bank_open`. READ and WRITE leave the open state unchanged.
- R9: Bank index i = rank*NUM_BANKS + bank. Requests, issues and open state of one bank never affect another bank.
- R10: `acc_valid` is high for exactly the one cycle after an accepting edge, with `acc_hit` valid alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_rank | input | RANK_W | Target rank |
| req_bank | input | BANK_W | Target bank within rank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_ready | output | 1 | Addressed bank queue is empty |
| acc_valid | output | 1 | A request was accepted on the previous edge |
| acc_hit | output | 1 | That request hit the open row |
| head_valid | output | NQ | Per-bank queue holds a command |
| head_cmd | output | NQ*2 | Per-bank head command code |
| head_row | output | NQ*ROW_W | Per-bank head command row |
| head_col | output | NQ*COL_W | Per-bank head command column |
| issue | input | NQ | Per-bank strobe: head command was sent |
| bank_open | output | NQ | Per-bank open-row flag |

## Verification
The conflict case is the hardest to reach: a bank must first hold a row, which happens only after a whole previous burst has drained through the issue strobes. The bench therefore opens a bank with a miss and drains it. It then sends a same-row hit and a write, drains those, and only then sends a different row to produce the precharge–activate–column burst. A scoreboard of expected commands per bank is filled when a request is sent and consumed as the bench fires issue strobes. Requests to other banks interleave with a pending queue, so cross-bank interference shows up as a mismatch.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [1:0] {
        CMD_PRE = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_WR  = 2'd3
    } dram_cmd_e;

    // longest burst one request can expand into
    localparam int BURST_MAX = 3;
    localparam int LEN_W     = $clog2(BURST_MAX + 1);

endpackage

// File: rtl/row_burst_decoder.sv
module row_burst_decoder
    import dram_seq_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic                            open_valid,
    input  logic [ROW_W-1:0]                open_row,
    input  logic [ROW_W-1:0]                want_row,
    input  logic                            want_write,
    output logic [LEN_W-1:0]                burst_len,
    output logic [BURST_MAX-1:0][1:0]       burst_cmd,
    output logic                            row_hit
);

    logic [1:0] col_cmd;

    always_comb begin
        col_cmd = want_write ? CMD_WR : CMD_RD;
        for (int k = 0; k < BURST_MAX; k++) begin
            burst_cmd[k] = col_cmd;
        end
        if (!open_valid) begin
            burst_len    = LEN_W'(2);
            burst_cmd[0] = CMD_ACT;
            row_hit      = 1'b0;
        end else if (open_row != want_row) begin
            burst_len    = LEN_W'(3);
            burst_cmd[0] = CMD_PRE;
            burst_cmd[1] = CMD_ACT;
            row_hit      = 1'b0;
        end else begin
            burst_len    = LEN_W'(1);
            row_hit      = 1'b1;
        end
    end

    always_comb begin
        assert (burst_len != '0 && burst_len <= LEN_W'(BURST_MAX))
            else $error("p_len_range_r2: burst length out of range");
        assert (burst_cmd[burst_len - LEN_W'(1)] == col_cmd)
            else $error("p_last_is_col_r5: burst does not end in column command");
    end

endmodule

// File: rtl/bank_cmd_queue.sv
module bank_cmd_queue
    import dram_seq_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int COL_W = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [LEN_W-1:0]            load_len,
    input  logic [BURST_MAX-1:0][1:0]   load_cmd,
    input  logic [ROW_W-1:0]            load_row,
    input  logic [COL_W-1:0]            load_col,
    input  logic                        pop,
    output logic                        head_valid,
    output logic [1:0]                  head_cmd,
    output logic [ROW_W-1:0]            head_row,
    output logic [COL_W-1:0]            head_col
);

    typedef struct packed {
        logic [BURST_MAX-1:0][1:0] cmd;
        logic [LEN_W-1:0]          cnt;
        logic [ROW_W-1:0]          row;
        logic [COL_W-1:0]          col;
    } queue_state_t;

    queue_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cmd = load_cmd;
            st_d.cnt = load_len;
            st_d.row = load_row;
            st_d.col = load_col;
        end else if (pop && st_q.cnt != '0) begin
            for (int k = 0; k < BURST_MAX - 1; k++) begin
                st_d.cmd[k] = st_q.cmd[k+1];
            end
            st_d.cmd[BURST_MAX-1] = CMD_PRE;
            st_d.cnt = st_q.cnt - LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_valid = (st_q.cnt != '0);
    assign head_cmd   = st_q.cmd[0];
    assign head_row   = st_q.row;
    assign head_col   = st_q.col;

    p_load_only_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> st_q.cnt == '0)
        else $error("p_load_only_empty_r6");

    p_pop_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && st_q.cnt > LEN_W'(1)) |=> head_cmd == $past(st_q.cmd[1]))
        else $error("p_pop_order_r7");

    p_empty_pop_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && st_q.cnt == '0 && !load) |=> !head_valid)
        else $error("p_empty_pop_ignored_r7");

    p_hold_without_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop && !load) |=> $stable(st_q))
        else $error("p_hold_without_strobe_r6");

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
    import dram_seq_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [1:0]       fire_cmd,
    input  logic [ROW_W-1:0] fire_row,
    output logic             open_valid,
    output logic [ROW_W-1:0] open_row
);

    typedef struct packed {
        logic             vld;
        logic [ROW_W-1:0] row;
    } row_state_t;

    row_state_t rs_q, rs_d;

    always_comb begin
        rs_d = rs_q;
        if (fire) begin
            case (fire_cmd)
                CMD_ACT: begin
                    rs_d.vld = 1'b1;
                    rs_d.row = fire_row;
                end
                CMD_PRE: rs_d.vld = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign open_valid = rs_q.vld;
    assign open_row   = rs_q.row;

    p_act_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && fire_cmd == CMD_ACT) |=> (open_valid && open_row == $past(fire_row)))
        else $error("p_act_opens_r8");

    p_pre_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && fire_cmd == CMD_PRE) |=> !open_valid)
        else $error("p_pre_closes_r8");

    p_column_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (fire_cmd == CMD_RD || fire_cmd == CMD_WR)) |=> $stable(open_valid))
        else $error("p_column_keeps_r8");

endmodule

// File: rtl/dram_bank_cmd_seq.sv
module dram_bank_cmd_seq
    import dram_seq_pkg::*;
#(
    parameter int NUM_RANKS = 2,
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 14,
    parameter int COL_W     = 10,
    localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int NQ       = NUM_RANKS * NUM_BANKS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [RANK_W-1:0]           req_rank,
    input  logic [BANK_W-1:0]           req_bank,
    input  logic [ROW_W-1:0]            req_row,
    input  logic [COL_W-1:0]            req_col,
    output logic                        req_ready,
    output logic                        acc_valid,
    output logic                        acc_hit,
    output logic [NQ-1:0]               head_valid,
    output logic [NQ-1:0][1:0]          head_cmd,
    output logic [NQ-1:0][ROW_W-1:0]    head_row,
    output logic [NQ-1:0][COL_W-1:0]    head_col,
    input  logic [NQ-1:0]               issue,
    output logic [NQ-1:0]               bank_open
);

    localparam int IDX_W = (NQ > 1) ? $clog2(NQ) : 1;

    typedef struct packed {
        logic             vld;
        logic             hit;
        logic [IDX_W-1:0] idx;
    } acc_state_t;

    logic [IDX_W-1:0]               tgt_idx;
    logic                           accept;
    logic [NQ-1:0]                  open_vld;
    logic [NQ-1:0][ROW_W-1:0]       open_row;
    logic [NQ-1:0]                  pop;
    logic                           sel_open_vld;
    logic [ROW_W-1:0]               sel_open_row;
    logic [LEN_W-1:0]               dec_len;
    logic [BURST_MAX-1:0][1:0]      dec_cmd;
    logic                           dec_hit;
    acc_state_t                     acc_q, acc_d;

    always_comb begin
        tgt_idx      = IDX_W'(req_rank) * IDX_W'(NUM_BANKS) + IDX_W'(req_bank);
        req_ready    = !head_valid[tgt_idx];
        accept       = req_valid && req_ready;
        sel_open_vld = open_vld[tgt_idx];
        sel_open_row = open_row[tgt_idx];
    end

    // one decoder serves whichever bank the request addresses
    row_burst_decoder #(
        .ROW_W      (ROW_W)
    ) u_decoder (
        .open_valid (sel_open_vld),
        .open_row   (sel_open_row),
        .want_row   (req_row),
        .want_write (req_write),
        .burst_len  (dec_len),
        .burst_cmd  (dec_cmd),
        .row_hit    (dec_hit)
    );

    for (genvar b = 0; b < NQ; b++) begin : g_bank
        logic load_here;

        assign load_here = accept && (tgt_idx == IDX_W'(b));
        assign pop[b]    = issue[b] && head_valid[b];

        bank_cmd_queue #(
            .ROW_W      (ROW_W),
            .COL_W      (COL_W)
        ) u_queue (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load_here),
            .load_len   (dec_len),
            .load_cmd   (dec_cmd),
            .load_row   (req_row),
            .load_col   (req_col),
            .pop        (pop[b]),
            .head_valid (head_valid[b]),
            .head_cmd   (head_cmd[b]),
            .head_row   (head_row[b]),
            .head_col   (head_col[b])
        );

        bank_row_tracker #(
            .ROW_W      (ROW_W)
        ) u_tracker (
            .clk        (clk),
            .rst_n      (rst_n),
            .fire       (pop[b]),
            .fire_cmd   (head_cmd[b]),
            .fire_row   (head_row[b]),
            .open_valid (open_vld[b]),
            .open_row   (open_row[b])
        );
    end

    always_comb begin
        acc_d     = acc_q;
        acc_d.vld = accept;
        if (accept) begin
            acc_d.hit = dec_hit;
            acc_d.idx = tgt_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc_valid = acc_q.vld;
    assign acc_hit   = acc_q.hit;
    assign bank_open = open_vld;

    p_miss_starts_row_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit) |->
            (head_valid[acc_q.idx] &&
             (head_cmd[acc_q.idx] == CMD_PRE || head_cmd[acc_q.idx] == CMD_ACT)))
        else $error("p_miss_starts_row_cmd_r2");

    p_conflict_pre_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit && bank_open[acc_q.idx]) |-> head_cmd[acc_q.idx] == CMD_PRE)
        else $error("p_conflict_pre_first_r3");

    p_hit_single_column_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit) |->
            (head_valid[acc_q.idx] && bank_open[acc_q.idx] &&
             (head_cmd[acc_q.idx] == CMD_RD || head_cmd[acc_q.idx] == CMD_WR)))
        else $error("p_hit_single_column_r4");

    p_blocked_no_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && head_valid[tgt_idx]) |=> !acc_valid)
        else $error("p_blocked_no_accept_r6");

    p_accept_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> acc_valid)
        else $error("p_accept_pulse_r10");

endmodule

// File: tb/test_dram_bank_cmd_seq.sv
module test_dram_bank_cmd_seq;

    localparam int NR = 2;
    localparam int NB = 4;
    localparam int RW = 14;
    localparam int CW = 10;
    localparam int NQ = NR * NB;

    localparam logic [1:0] PRE = 2'd0;
    localparam logic [1:0] ACT = 2'd1;
    localparam logic [1:0] RD  = 2'd2;
    localparam logic [1:0] WR  = 2'd3;

    typedef struct packed {
        logic [1:0]    c;
        logic [RW-1:0] r;
        logic [CW-1:0] l;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [0:0] req_rank = '0;
    logic [1:0] req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic req_ready, acc_valid, acc_hit;
    logic [NQ-1:0] head_valid;
    logic [NQ-1:0][1:0] head_cmd;
    logic [NQ-1:0][RW-1:0] head_row;
    logic [NQ-1:0][CW-1:0] head_col;
    logic [NQ-1:0] issue = '0;
    logic [NQ-1:0] bank_open;

    int checks = 0;
    int errors = 0;

    item_t         sb [NQ][$];
    bit            m_open [NQ];
    logic [RW-1:0] m_row  [NQ];

    always #4 clk = ~clk;

    dram_bank_cmd_seq #(
        .NUM_RANKS (NR),
        .NUM_BANKS (NB),
        .ROW_W     (RW),
        .COL_W     (CW)
    ) i_dram_bank_cmd_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_rank   (req_rank),
        .req_bank   (req_bank),
        .req_row    (req_row),
        .req_col    (req_col),
        .req_ready  (req_ready),
        .acc_valid  (acc_valid),
        .acc_hit    (acc_hit),
        .head_valid (head_valid),
        .head_cmd   (head_cmd),
        .head_row   (head_row),
        .head_col   (head_col),
        .issue      (issue),
        .bank_open  (bank_open)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: sends one request and fills the scoreboard with its expected burst
    task automatic send(input bit w, input int rk, input int bk, input int row, input int col,
                        input string tag);
        int    idx = rk * NB + bk;
        bit    hit = m_open[idx] && (m_row[idx] == RW'(row));
        item_t it;
        it.r = RW'(row);
        it.l = CW'(col);
        if (!hit && m_open[idx]) begin
            it.c = PRE; sb[idx].push_back(it);
        end
        if (!hit) begin
            it.c = ACT; sb[idx].push_back(it);
        end
        it.c = w ? WR : RD;
        sb[idx].push_back(it);
        req_write = w;
        req_rank  = 1'(rk);
        req_bank  = 2'(bk);
        req_row   = RW'(row);
        req_col   = CW'(col);
        req_valid = 1'b1;
        #1;
        chk(req_ready == 1'b1, {tag, " R6 ready on empty bank"}, req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(acc_valid == 1'b1, {tag, " R10 acc_valid after accept"}, acc_valid, 1);
        chk(acc_hit == hit, {tag, " R2 R3 R4 row hit flag"}, acc_hit, hit);
        @(negedge clk);
        chk(acc_valid == 1'b0, {tag, " R10 acc_valid single cycle"}, acc_valid, 0);
    endtask

    // monitor: issues queue i until empty, comparing each head with the scoreboard
    task automatic drain(input int idx, input string tag);
        while (sb[idx].size() > 0) begin
            item_t e = sb[idx].pop_front();
            chk(head_valid[idx] == 1'b1, {tag, " R7 head present"}, head_valid[idx], 1);
            chk(head_cmd[idx] == e.c, {tag, " R2 R3 R5 command order"}, head_cmd[idx], e.c);
            chk(head_row[idx] == e.r, {tag, " R5 row field"}, head_row[idx], e.r);
            chk(head_col[idx] == e.l, {tag, " R5 column field"}, head_col[idx], e.l);
            issue[idx] = 1'b1;
            @(posedge clk);
            @(negedge clk);
            issue[idx] = 1'b0;
            if (e.c == ACT) begin
                m_open[idx] = 1'b1;
                m_row[idx]  = e.r;
            end else if (e.c == PRE) begin
                m_open[idx] = 1'b0;
            end
            chk(bank_open[idx] == m_open[idx], {tag, " R8 open flag after issue"},
                bank_open[idx], m_open[idx]);
        end
        chk(head_valid[idx] == 1'b0, {tag, " R7 queue empty after drain"}, head_valid[idx], 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NQ; i++) begin
            m_open[i] = 1'b0;
            m_row[i]  = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk(head_valid == '0, "R1 queues empty", head_valid, 0);
        chk(bank_open == '0, "R1 no bank open", bank_open, 0);
        chk(acc_valid == 1'b0, "R1 acc_valid low", acc_valid, 0);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);

        send(0, 0, 0, 5, 17, "R2 closed read");
        drain(0, "R2");
        send(0, 0, 0, 5, 33, "R4 hit read");
        drain(0, "R4");
        send(1, 0, 0, 5, 40, "R5 hit write");
        drain(0, "R5");
        send(0, 0, 0, 9, 2, "R3 conflict read");
        drain(0, "R3");
        send(1, 0, 0, 12, 1023, "R3 conflict write");
        drain(0, "R3w");

        // R9: two banks pending at once, drained in reverse order
        send(1, 1, 2, 3, 7, "R9 bank6");
        send(0, 0, 1, 3, 8, "R9 bank1");
        chk(bank_open[6] == 1'b0, "R9 bank6 untouched", bank_open[6], 0);
        drain(1, "R9 b1");
        chk(head_valid[6] == 1'b1, "R9 bank6 still pending", head_valid[6], 1);
        drain(6, "R9 b6");
        send(0, 1, 2, 3, 9, "R9 bank6 hit after bank1 traffic");
        drain(6, "R9 b6 hit");

        // R6: blocked request is ignored
        send(0, 0, 2, 100, 4, "R6 first");
        req_write = 1'b1;
        req_rank  = 1'b0;
        req_bank  = 2'd2;
        req_row   = RW'(200);
        req_col   = CW'(9);
        req_valid = 1'b1;
        #1;
        chk(req_ready == 1'b0, "R6 ready low on busy bank", req_ready, 0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(acc_valid == 1'b0, "R6 no accept when busy", acc_valid, 0);
        drain(2, "R6 original burst intact");

        // R7: issue to an empty queue changes nothing
        issue[3] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        issue[3] = 1'b0;
        chk(head_valid[3] == 1'b0, "R7 empty issue keeps queue empty", head_valid[3], 0);
        chk(bank_open[3] == 1'b0, "R7 empty issue keeps bank closed", bank_open[3], 0);
        send(0, 0, 3, 50, 5, "R7 bank3 still closed-row miss");
        drain(3, "R7 b3");

        // patterned traffic over every bank
        for (int k = 0; k < 24; k++) begin
            int b = (k * 3) % NQ;
            send(k[0], b / NB, b % NB, (k % 3) * 11, k, "R9 pattern");
            drain(b, "R9 pattern");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule